// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column addresses of one SDRAM read or write burst, one address per clock. A controller pulses a start strobe together with a starting column, a burst length code and an order bit. The generator then emits the burst's columns in the order the memory walks them. The walk is either sequential or interleaved, and it always stays inside the aligned block whose size equals the burst length. A full-page mode walks the whole 512-column row in sequential order and keeps going until a terminate input ends it.

Every output is registered. The first address appears in the cycle after the start strobe is sampled. A valid flag marks each cycle that carries an address, and a last flag marks the final address of the burst. A length code that is not allowed raises a one-cycle error flag and produces no addresses. A new start strobe always takes priority over a burst that is still running.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, `col_o`, `valid_o`, `last_o` and `err_o` are all 0.
- R2: Length codes on `len_code_i`: 000 gives 1 address, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives full page, which is allowed only when `interleave_i`=0. The edge that samples a valid start is followed by `valid_o`=1 with `col_o` equal to the start column.
- R3: For every address of a fixed-length burst of length L, the column bits above log2(L) are equal to those of the start column. In other words, the burst wraps inside its aligned block.
- R4: With `interleave_i`=0, the k-th address (k counted from 0) has low bits equal to (start low bits + k) mod L. For example, start 5 with length 8 gives 5,6,7,0,1,2,3,4.
- R5: With `interleave_i`=1, the k-th address has low bits equal to the start low bits XOR k. For example, start 5 with length 8 gives 5,4,7,6,1,0,3,2.
- R6: Length code 000 emits exactly one address, the start column, with `last_o`=1, whatever the value of `interleave_i`.
- R7: In full-page mode the k-th address is (start + k) mod 512, and the burst runs until `term_i` is sampled high. The address emitted at that edge carries `last_o`=1, and `valid_o` is 0 on the next cycle.
- R8: Codes 100, 101 and 110, and code 111 with `interleave_i`=1, make `err_o`=1 for one cycle and produce no address (`valid_o`=0).
- R9: `last_o` is 1 exactly with the L-th address of a fixed-length burst. `term_i` has no effect on a fixed-length burst.
- R10: A start sampled while a burst is running drops that burst. The next cycle carries the new start column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for a new burst |
| start_col_i | input | 9 | Starting column |
| len_code_i | input | 3 | Burst length code |
| interleave_i | input | 1 | 0 selects sequential order, 1 selects interleaved order |
| term_i | input | 1 | Ends a full-page burst |
| col_o | output | 9 | Column address |
| valid_o | output | 1 | `col_o` carries an address |
| last_o | output | 1 | Final address of the burst |
| err_o | output | 1 | Start with a reserved length code |

## Verification
The assertions assume that `start_col_i`, `len_code_i` and `interleave_i` are stable and meaningful whenever `start_i` is high. They also assume that `term_i` is only treated as meaningful while a full-page burst is running. The bench changes inputs only on falling edges. It raises the start strobe for exactly one cycle, except in the restart scenario, where a second strobe is deliberately placed inside a running burst. It raises the terminate input for a single cycle in full-page runs, and holds it high throughout the one fixed-length run that checks it is ignored.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  localparam int COL_W      = 9;
  localparam int CODE_W     = 3;
  localparam int FIXED_CODES = 4;
  localparam logic [CODE_W-1:0] FULL_CODE = 3'b111;
endpackage

// File: rtl/colgen_len_decode.sv
module colgen_len_decode
  import colgen_pkg::*;
#(
  parameter int COL_WIDTH = COL_W,
  parameter int CODE_WIDTH = CODE_W,
  parameter int NUM_FIXED = FIXED_CODES,
  parameter logic [CODE_WIDTH-1:0] FULL_VAL = FULL_CODE
) (
  input  logic [CODE_WIDTH-1:0] code_i,
  input  logic                  ilv_i,
  output logic [COL_WIDTH-1:0]  mask_o,
  output logic                  full_o,
  output logic                  bad_o
);
  always_comb begin
    mask_o = '0;
    full_o = 1'b0;
    bad_o  = 1'b0;
    if (32'(code_i) < NUM_FIXED) begin
      mask_o = ~({COL_WIDTH{1'b1}} << code_i);
    end else if (code_i == FULL_VAL && !ilv_i) begin
      mask_o = '1;
      full_o = 1'b1;
    end else begin
      bad_o = 1'b1;
    end
  end
endmodule

// File: rtl/colgen_order.sv
module colgen_order
  import colgen_pkg::*;
#(
  parameter int COL_WIDTH = COL_W
) (
  input  logic [COL_WIDTH-1:0] base_i,
  input  logic [COL_WIDTH-1:0] mask_i,
  input  logic                 ilv_i,
  input  logic [COL_WIDTH-1:0] step_i,
  output logic [COL_WIDTH-1:0] col_o
);
  logic [COL_WIDTH-1:0] low;
  always_comb begin
    low   = ilv_i ? (base_i ^ step_i) : (base_i + step_i);
    col_o = (base_i & ~mask_i) | (low & mask_i);
  end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_WIDTH = COL_W,
  parameter int CODE_WIDTH = CODE_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic [COL_WIDTH-1:0]  start_col_i,
  input  logic [CODE_WIDTH-1:0] len_code_i,
  input  logic                  interleave_i,
  input  logic                  term_i,
  output logic [COL_WIDTH-1:0]  col_o,
  output logic                  valid_o,
  output logic                  last_o,
  output logic                  err_o
);
  logic [COL_WIDTH-1:0] dec_mask;
  logic                 dec_full;
  logic                 dec_bad;

  logic                 act_q;
  logic [COL_WIDTH-1:0] base_q;
  logic [COL_WIDTH-1:0] mask_q;
  logic                 ilv_q;
  logic                 full_q;
  logic [COL_WIDTH-1:0] step_q;
  logic [COL_WIDTH-1:0] nxt_col;

  colgen_len_decode #(.COL_WIDTH(COL_WIDTH), .CODE_WIDTH(CODE_WIDTH)) u_dec (
    .code_i (len_code_i),
    .ilv_i  (interleave_i),
    .mask_o (dec_mask),
    .full_o (dec_full),
    .bad_o  (dec_bad)
  );

  colgen_order #(.COL_WIDTH(COL_WIDTH)) u_ord (
    .base_i (base_q),
    .mask_i (mask_q),
    .ilv_i  (ilv_q),
    .step_i (step_q),
    .col_o  (nxt_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      base_q  <= '0;
      mask_q  <= '0;
      ilv_q   <= 1'b0;
      full_q  <= 1'b0;
      step_q  <= '0;
      col_o   <= '0;
      valid_o <= 1'b0;
      last_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      err_o <= 1'b0;
      if (start_i) begin
        if (dec_bad) begin
          act_q   <= 1'b0;
          valid_o <= 1'b0;
          last_o  <= 1'b0;
          err_o   <= 1'b1;
        end else begin
          base_q  <= start_col_i;
          mask_q  <= dec_mask;
          ilv_q   <= interleave_i;
          full_q  <= dec_full;
          step_q  <= {{(COL_WIDTH-1){1'b0}}, 1'b1};
          col_o   <= start_col_i;
          valid_o <= 1'b1;
          last_o  <= (dec_mask == '0);
          act_q   <= (dec_mask != '0);
        end
      end else if (act_q) begin
        col_o   <= nxt_col;
        valid_o <= 1'b1;
        step_q  <= step_q + 1'b1;
        if (full_q) begin
          last_o <= term_i;
          act_q  <= ~term_i;
        end else begin
          last_o <= (step_q == mask_q);
          act_q  <= (step_q != mask_q);
        end
      end else begin
        valid_o <= 1'b0;
        last_o  <= 1'b0;
      end
    end
  end

  // R9: last only accompanies an address
  a_r9_last_has_valid: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o);

  // R8: an error cycle carries no address
  a_r8_err_no_valid: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !valid_o);

  // R3: every address stays inside the aligned block of the start column
  a_r3_in_block: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (((col_o ^ base_q) & ~mask_q) == '0));

  // R2 / R10: an accepted start shows its column on the next cycle
  a_r2_first_addr: assert property (@(posedge clk) disable iff (rst)
    (start_i && !dec_bad) |=> (valid_o && col_o == $past(start_col_i)));

  // R9: nothing follows the final address without a new start
  a_r9_idle_after_last: assert property (@(posedge clk) disable iff (rst)
    (last_o && !start_i) |=> !valid_o);

  // R7: full-page addresses step by one, wrapping in the row
  a_r7_full_step: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o && full_q && !start_i) |=>
      (col_o == COL_WIDTH'($past(col_o) + 1'b1)));
endmodule

// File: tb/sdram_burst_colgen_bench.sv
`timescale 1ns/1ps
module sdram_burst_colgen_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       start_i;
  logic [8:0] start_col_i;
  logic [2:0] len_code_i;
  logic       interleave_i;
  logic       term_i;
  logic [8:0] col_o;
  logic       valid_o;
  logic       last_o;
  logic       err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sdram_burst_colgen u_sdram_burst_colgen (
    .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .interleave_i(interleave_i), .term_i(term_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] exp_col(input logic [8:0] s, input int code,
                                         input bit ilv, input int k);
    logic [8:0] m;
    logic [8:0] lo;
    m  = 9'((1 << code) - 1);
    lo = ilv ? (s ^ 9'(k)) : (s + 9'(k));
    return (s & ~m) | (lo & m);
  endfunction

  task automatic pulse_start(input logic [8:0] c, input logic [2:0] code, input bit ilv);
    start_i = 1'b1; start_col_i = c; len_code_i = code; interleave_i = ilv;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // checks the outputs from the current address k0 to the end of the burst
  task automatic follow(input logic [8:0] s, input int code, input bit ilv,
                        input int k0, input string tag);
    int len = 1 << code;
    for (int k = k0; k < len; k++) begin
      check(valid_o === 1'b1, {tag, " valid"}, int'(valid_o), 1);
      check(col_o === exp_col(s, code, ilv, k), {tag, " col"}, int'(col_o),
            int'(exp_col(s, code, ilv, k)));
      check(last_o === (k == len - 1), {tag, " last"}, int'(last_o), int'(k == len - 1));
      @(negedge clk);
    end
    check(valid_o === 1'b0, {tag, " idle after"}, int'(valid_o), 0);
  endtask

  task automatic t_fixed(input logic [8:0] s, input int code, input bit ilv, input string tag);
    pulse_start(s, 3'(code), ilv);
    follow(s, code, ilv, 0, tag);
  endtask

  task automatic t_reset;
    check(col_o === 9'd0, "R1 col", int'(col_o), 0);
    check(valid_o === 1'b0, "R1 valid", int'(valid_o), 0);
    check(last_o === 1'b0, "R1 last", int'(last_o), 0);
    check(err_o === 1'b0, "R1 err", int'(err_o), 0);
  endtask

  task automatic t_full(input logic [8:0] s, input int n, input string tag);
    pulse_start(s, 3'b111, 1'b0);
    check(valid_o === 1'b1 && col_o === s, {tag, " first"}, int'(col_o), int'(s));
    for (int k = 1; k < n; k++) begin
      if (k == n - 1) term_i = 1'b1;
      @(negedge clk);
      check(col_o === 9'(s + 9'(k)), {tag, " col"}, int'(col_o), int'(9'(s + 9'(k))));
      check(last_o === (k == n - 1), {tag, " last"}, int'(last_o), int'(k == n - 1));
    end
    term_i = 1'b0;
    @(negedge clk);
    check(valid_o === 1'b0, {tag, " stop"}, int'(valid_o), 0);
  endtask

  task automatic t_reserved(input logic [2:0] code, input bit ilv, input string tag);
    pulse_start(9'd37, code, ilv);
    check(err_o === 1'b1, {tag, " err"}, int'(err_o), 1);
    check(valid_o === 1'b0, {tag, " no addr"}, int'(valid_o), 0);
    @(negedge clk);
    check(err_o === 1'b0, {tag, " err pulse"}, int'(err_o), 0);
    check(valid_o === 1'b0, {tag, " still none"}, int'(valid_o), 0);
  endtask

  task automatic t_restart;
    pulse_start(9'd100, 3'd3, 1'b0);
    @(negedge clk);
    @(negedge clk);
    pulse_start(9'd203, 3'd2, 1'b1);
    follow(9'd203, 2, 1'b1, 0, "R10 restart");
  endtask

  task automatic t_term_fixed;
    term_i = 1'b1;
    t_fixed(9'd58, 2, 1'b0, "R9 term ignored");
    term_i = 1'b0;
  endtask

  initial begin
    rst = 1'b1; start_i = 1'b0; start_col_i = '0; len_code_i = '0;
    interleave_i = 1'b0; term_i = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fixed(9'd77, 0, 1'b0, "R6 single seq");
    t_fixed(9'd77, 0, 1'b1, "R6 single ilv");
    t_fixed(9'd13, 1, 1'b0, "R2 len2 seq");
    t_fixed(9'd13, 1, 1'b1, "R5 len2 ilv");
    t_fixed(9'd42, 2, 1'b0, "R4 len4 seq");
    t_fixed(9'd43, 2, 1'b1, "R5 len4 ilv");
    t_fixed(9'd5, 3, 1'b0, "R4 len8 seq wrap R3");
    t_fixed(9'd5, 3, 1'b1, "R5 len8 ilv");
    t_fixed(9'd511, 3, 1'b0, "R3 top block");
    t_full(9'd200, 6, "R7 full");
    t_full(9'd509, 7, "R7 full wrap");
    t_reserved(3'b100, 1'b0, "R8 code4");
    t_reserved(3'b110, 1'b1, "R8 code6");
    t_reserved(3'b111, 1'b1, "R8 full ilv");
    t_restart();
    t_term_fixed();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule